// File: doc/BRIEF.md
# Four-Phase Handshake Register Slave

This block is a small 16-bit register slave on a simple internal bus. The bus has separate read and write data paths, a select, a read strobe, a 4-bit word address and an acknowledge. A master starts an access by raising select. The slave answers with an acknowledge and keeps it high until select falls, and only then releases it. Because of this four-phase handshake, master and slave may run on unrelated clocks. Select is brought into the slave clock through a two-flop synchronizer. Address, read strobe and write data are taken directly, because the master keeps them stable while select is high.

Several slaves can share one bus. The master merges their read data and acknowledges with a plain OR, so this slave drives zero on both whenever it is not acknowledging. The register map has four kinds of location:
- a transmit control word holding the scramble enable and the frame check size select;
- a general read/write control word;
- read-only status words sampled from input pins;
- every other address, which reads as zero.

A handshake state machine sequences each access through three states:
- HS_IDLE: waiting for a synchronized select. It moves to HS_ACCESS when select is seen high.
- HS_ACCESS: a single cycle in which a write is committed or read data is captured. It always moves to HS_ACK.
- HS_ACK: the acknowledge is driven. The machine stays here while the synchronized select is high and returns to HS_IDLE once it is low.

Top module: `fourphase_reg_slave`

## Requirements
- R1: After reset, bus_ack is 0, bus_rdata is 0, tx_scramble_en is 0, tx_crc32_sel is 0 and gp_ctrl is 0.
- R2: With select sampled high at a rising edge, bus_ack rises after the fourth rising edge, counting that edge as the first. It then stays high for as long as select stays high.
- R3: After select is sampled low, bus_ack falls after the third rising edge. A new access is only accepted after this release.
- R4: bus_rdata is zero in every cycle in which bus_ack is low.
- R5: Word address 0 is the transmit control register. A write sets tx_scramble_en from bit 0 and tx_crc32_sel from bit 1, where 1 selects CRC-32 and 0 selects CRC-16. A read returns these two bits in positions 0 and 1 with all other bits zero.
- R6: Word address 1 is a 16-bit read/write control word that drives gp_ctrl and reads back in full.
- R7: Word addresses 8 and 9 return status_i[15:0] and status_i[31:16] respectively. Writes to them are acknowledged and have no effect.
- R8: A read of any other address (2 to 7, 10 to 15) is acknowledged and returns 0. A write to such an address is acknowledged and changes no register.
- R9: A write takes effect once per select assertion, in the access cycle. Write data that changes after the acknowledge rises is ignored.
- R10: A read (bus_rd = 1) changes no register, whatever the value on bus_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access select from the master; may be asynchronous |
| bus_rd | input | 1 | 1 = read, 0 = write; stable while select is high |
| bus_addr | input | 4 | Word address; stable while select is high |
| bus_wdata | input | 16 | Write data; stable while select is high |
| bus_rdata | output | 16 | Read data; zero when not acknowledging |
| bus_ack | output | 1 | Acknowledge, held until select is released |
| status_i | input | 32 | Two read-only status words (low word at address 8) |
| tx_scramble_en | output | 1 | Scrambler enable from the transmit control register |
| tx_crc32_sel | output | 1 | Frame check size select: 1 = CRC-32, 0 = CRC-16 |
| gp_ctrl | output | 16 | General control word |

## Verification
Accesses are tried against each kind of location, and each pattern separates a different fault:
- **Transmit control register:** distinct bit patterns catch swapped or mis-positioned bits.
- **Full control word:** all-ones and alternating values catch truncated storage.
- **Status words:** two different values catch a wrong word being selected.
- **Unmapped and read-only locations:** reads and writes here expose decode aliasing, and writes that leak into mapped registers.

Each access also measures how many cycles the acknowledge takes to rise and to fall, which catches a missing or extra synchronizer stage or state. A long-held select with write data changed mid-access tells a single write apart from repeated writes. Reads issued with all-ones write data show whether the read strobe is honoured.

// File: rtl/fourphase_reg_pkg.sv
package fourphase_reg_pkg;

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_ACCESS = 2'd1,
        HS_ACK    = 2'd2
    } hs_state_t;

endpackage

// File: rtl/hs_sel_sync.sv
module hs_sel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
    import fourphase_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    output logic acc_o,
    output logic ack_o
);
    hs_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:   state_d = sel_s ? HS_ACCESS : HS_IDLE;
            HS_ACCESS: state_d = HS_ACK;
            HS_ACK:    state_d = sel_s ? HS_ACK : HS_IDLE;
            default:   state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        acc_o = 1'b0;
        ack_o = 1'b0;
        unique case (state_q)
            HS_IDLE:   ;
            HS_ACCESS: acc_o = 1'b1;
            HS_ACK:    ack_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/hs_regfile.sv
module hs_regfile #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int RO_BASE  = 8,
    parameter int RO_COUNT = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [RO_COUNT*DATA_W-1:0] status_i,
    output logic [DATA_W-1:0]          rword,
    output logic                       scr_en,
    output logic                       crc32_sel,
    output logic [DATA_W-1:0]          gp_q
);
    localparam logic [ADDR_W-1:0] TXCTL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] GP_ADDR    = ADDR_W'(1);

    logic [1:0] txctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txctl_q <= '0;
            gp_q    <= '0;
        end else if (wr_en) begin
            if (addr == TXCTL_ADDR) txctl_q <= wdata[1:0];
            if (addr == GP_ADDR)    gp_q    <= wdata;
        end
    end

    assign scr_en    = txctl_q[0];
    assign crc32_sel = txctl_q[1];

    logic [RO_COUNT-1:0] ro_hit;
    logic [DATA_W-1:0]   ro_word;

    for (genvar g = 0; g < RO_COUNT; g++) begin : g_ro_dec
        assign ro_hit[g] = (addr == ADDR_W'(RO_BASE + g));
    end

    always_comb begin
        ro_word = '0;
        for (int i = 0; i < RO_COUNT; i++) begin
            if (ro_hit[i]) ro_word = status_i[i*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        if (addr == TXCTL_ADDR)   rword = {{(DATA_W-2){1'b0}}, txctl_q};
        else if (addr == GP_ADDR) rword = gp_q;
        else                      rword = ro_word;
    end
endmodule

// File: rtl/fourphase_reg_slave.sv
module fourphase_reg_slave #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int RO_BASE     = 8,
    parameter int RO_COUNT    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_ack,
    input  logic [RO_COUNT*DATA_W-1:0] status_i,
    output logic                       tx_scramble_en,
    output logic                       tx_crc32_sel,
    output logic [DATA_W-1:0]          gp_ctrl
);
    logic              sel_s;
    logic              acc_pulse;
    logic              wr_en;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] hold_q;

    hs_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(bus_sel), .sync_o(sel_s)
    );

    hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_s(sel_s),
        .acc_o(acc_pulse), .ack_o(bus_ack)
    );

    assign wr_en = acc_pulse & ~bus_rd;

    hs_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RO_BASE(RO_BASE), .RO_COUNT(RO_COUNT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .status_i(status_i), .rword(rword),
        .scr_en(tx_scramble_en), .crc32_sel(tx_crc32_sel), .gp_q(gp_ctrl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hold_q <= '0;
        else if (acc_pulse) hold_q <= bus_rd ? rword : '0;
    end

    assign bus_rdata = bus_ack ? hold_q : '0;
endmodule

// File: rtl/fourphase_reg_slave_chk.sv
module fourphase_reg_slave_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ack,
    input logic              acc,
    input logic              scr,
    input logic              crc
);
    // R4: merged-bus safety, no data without acknowledge
    a_r4_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == '0));

    // R2: acknowledge is held while select is present
    a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_sel) |=> bus_ack);

    // R2: acknowledge only rises for a select seen three edges earlier
    a_r2_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(bus_sel, 3));

    // R9: one access cycle per select assertion
    a_r9_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !acc);

    // R5: transmit control only changes after a write to word 0
    a_r5_txctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && !bus_rd && bus_addr == '0) |=> $stable({scr, crc}));
endmodule

bind fourphase_reg_slave fourphase_reg_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .acc(acc_pulse), .scr(tx_scramble_en), .crc(tx_crc32_sel)
);

// File: tb/fourphase_reg_slave_bench.sv
module fourphase_reg_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ack;
    logic [31:0] status_i = 32'hBEEF_1234;
    logic        tx_scramble_en, tx_crc32_sel;
    logic [15:0] gp_ctrl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    fourphase_reg_slave u_fourphase_reg_slave (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .status_i(status_i), .tx_scramble_en(tx_scramble_en),
        .tx_crc32_sel(tx_crc32_sel), .gp_ctrl(gp_ctrl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one complete four-phase access; checks latency (R2, R3) and zero data before ack (R4)
    task automatic access(input logic rd, input logic [3:0] a, input logic [15:0] wd,
                          output logic [15:0] rdat);
        int lat = 0;
        int rel = 0;
        bit leak = 0;
        @(negedge clk);
        bus_rd = rd; bus_addr = a; bus_wdata = wd; bus_sel = 1'b1;
        while (!bus_ack && lat < 20) begin
            @(negedge clk);
            lat++;
            if (!bus_ack && bus_rdata != 16'h0) leak = 1;
        end
        rdat = bus_rdata;
        bus_sel = 1'b0;
        while (bus_ack && rel < 20) begin
            @(negedge clk);
            rel++;
            if (!bus_ack && bus_rdata != 16'h0) leak = 1;
        end
        chk("R2 ack rise latency", lat, 4);
        chk("R3 ack release latency", rel, 3);
        chk("R4 rdata zero without ack", {31'd0, leak}, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset ack", {31'd0, bus_ack}, 0);
        chk("R1 reset rdata", {16'd0, bus_rdata}, 0);
        chk("R1 reset scramble", {31'd0, tx_scramble_en}, 0);
        chk("R1 reset crc32", {31'd0, tx_crc32_sel}, 0);
        chk("R1 reset gp", {16'd0, gp_ctrl}, 0);
    endtask

    task automatic t_txctl();
        logic [15:0] r;
        access(1'b0, 4'd0, 16'hFFFD, r);
        chk("R5 write 01 scramble", {31'd0, tx_scramble_en}, 1);
        chk("R5 write 01 crc32", {31'd0, tx_crc32_sel}, 0);
        access(1'b1, 4'd0, 16'h0, r);
        chk("R5 read 01", {16'd0, r}, 32'h1);
        access(1'b0, 4'd0, 16'h0002, r);
        chk("R5 write 10 scramble", {31'd0, tx_scramble_en}, 0);
        chk("R5 write 10 crc32", {31'd0, tx_crc32_sel}, 1);
        access(1'b1, 4'd0, 16'h0, r);
        chk("R5 read 10", {16'd0, r}, 32'h2);
    endtask

    task automatic t_gp();
        logic [15:0] r;
        access(1'b0, 4'd1, 16'hFFFF, r);
        access(1'b1, 4'd1, 16'h0, r);
        chk("R6 read ones", {16'd0, r}, 32'hFFFF);
        access(1'b0, 4'd1, 16'h5AC3, r);
        chk("R6 gp output", {16'd0, gp_ctrl}, 32'h5AC3);
        access(1'b1, 4'd1, 16'h0, r);
        chk("R6 read pattern", {16'd0, r}, 32'h5AC3);
    endtask

    task automatic t_status();
        logic [15:0] r;
        access(1'b1, 4'd8, 16'h0, r);
        chk("R7 status low", {16'd0, r}, 32'h1234);
        access(1'b1, 4'd9, 16'h0, r);
        chk("R7 status high", {16'd0, r}, 32'hBEEF);
        access(1'b0, 4'd8, 16'h7777, r);
        access(1'b0, 4'd9, 16'h7777, r);
        access(1'b1, 4'd8, 16'h0, r);
        chk("R7 status write ignored", {16'd0, r}, 32'h1234);
        chk("R7 gp untouched", {16'd0, gp_ctrl}, 32'h5AC3);
        status_i = 32'h0F0F_A0A0;
        access(1'b1, 4'd9, 16'h0, r);
        chk("R7 status live", {16'd0, r}, 32'h0F0F);
    endtask

    task automatic t_unmapped();
        logic [15:0] r;
        for (int a = 2; a < 16; a++) begin
            if (a == 8 || a == 9) continue;
            access(1'b0, 4'(a), 16'hFFFF, r);
            access(1'b1, 4'(a), 16'h0, r);
            chk("R8 unmapped reads zero", {16'd0, r}, 0);
        end
        chk("R8 gp untouched", {16'd0, gp_ctrl}, 32'h5AC3);
        chk("R8 txctl untouched", {30'd0, tx_crc32_sel, tx_scramble_en}, 32'h2);
    endtask

    task automatic t_hold_once();
        logic [15:0] r;
        bit dropped = 0;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 4'd1; bus_wdata = 16'hA5A5; bus_sel = 1'b1;
        for (int i = 0; i < 20 && !bus_ack; i++) @(negedge clk);
        bus_wdata = 16'h0F0F;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!bus_ack) dropped = 1;
        end
        chk("R2 ack held with select", {31'd0, dropped}, 0);
        bus_sel = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        access(1'b1, 4'd1, 16'h0, r);
        chk("R9 late wdata ignored", {16'd0, r}, 32'hA5A5);
    endtask

    task automatic t_read_no_effect();
        logic [15:0] r;
        access(1'b1, 4'd0, 16'hFFFF, r);
        access(1'b1, 4'd1, 16'hFFFF, r);
        chk("R10 read leaves txctl", {30'd0, tx_crc32_sel, tx_scramble_en}, 32'h2);
        chk("R10 read leaves gp", {16'd0, gp_ctrl}, 32'hA5A5);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_txctl();
        t_gp();
        t_status();
        t_unmapped();
        t_hold_once();
        t_read_no_effect();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule